// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from twelve sources and presents a single prioritised level to the processor. The sources are power fail, bus error, the abort push-button, serial, ethernet, SCSI, DMA, printer, two timers and two software-raised interrupts. Each source has one control byte that holds an enable bit, a three-bit level and a pending flag. Software clears the pending flag by writing a one to it. A general control register carries a single global enable, and a vector-base register supplies the upper part of every vector.

The processor sees the highest level among the sources that are pending and enabled. It answers with an acknowledge strobe that carries the level it is servicing. One cycle later the block returns an eight-bit vector: the base plus the winning source's fixed index. Edge-type sources lose their pending flag when they win an acknowledge. Level-type sources keep theirs for as long as the peripheral holds its request.

Per-source behaviour depends on the source's kind:
- Edge-type sources are bus error, DMA and the two timers.
- Level-type sources are power fail, serial, ethernet, SCSI and printer.
- The two software sources are set and cleared by register writes only.
- The abort source follows a synchronised, active-low push-button input.

Top module: `vic_top`

## Requirements
- R1: After reset every control byte, the general control register and the vector base read 0, and `irq_lvl` is 0.
- R2: Register map:
  - Addresses 0 to 11 are the control bytes of source index 0 to 11. Each byte has bit 7 pending (read) / clear (write one), bit 6 abort switch state (abort byte only, else 0), bit 3 enable, and bits 2:0 level.
  - Address 12 is general control, with only bit 4 (global enable) stored and read back.
  - Address 13 is the vector base.
  - Writes to addresses 14 and 15 are ignored, and those addresses read 0.
- R3: `irq_lvl` is the largest level among sources that are pending and enabled, or 0 if there are none. A source whose level is 0 never raises it. While the global enable is 0, `irq_lvl` is 0.
- R4: One cycle after a clock edge that samples `iack` high, `vec_valid` is high for one cycle. `vec` then equals the vector base plus the winning source index, modulo 256.
- R5: At the acknowledged level the winner is the lowest-index source that is pending, enabled and at that level.
- R6: If no source qualifies (including when the global enable is 0 or `iack_lvl` is 0), the returned vector is 0xFF.
- R7: Edge-type sources (1, 6, 8, 9) become pending on a rising edge of their `src_req` bit. They are cleared by a write of bit 7 = 1 or by winning an acknowledge.
- R8: Level-type sources (0, 3, 4, 5, 7) show as pending the request value sampled at the previous clock edge. Writes of bit 7 and acknowledges do not affect them.
- R9: A rising request edge in the same cycle as a clear keeps an edge-type source pending.
- R10: Software sources (10, 11) behave as follows:
  - Writing their byte with bit 3 = 1 and bit 7 = 0 makes them pending.
  - Writing bit 7 = 1 clears them, and the clear wins when bits 7 and 3 are both 1.
  - Acknowledges and `src_req` do not affect them.
- R11: The abort source's input `abort_n` is synchronised through two flip-flops:
  - Bit 6 of its byte reads 1 from the second clock edge after `abort_n` falls.
  - Its pending flag sets on the third clock edge.
  - It clears like an edge-type source.
- R12: A source keeps a latched pending flag while disabled and contributes to `irq_lvl` as soon as it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| src_req | input | 12 | Peripheral request lines, bit = source index |
| abort_n | input | 1 | Asynchronous abort switch, low when pressed |
| iack | input | 1 | Acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| irq_lvl | output | 3 | Highest active level |
| vec_valid | output | 1 | Vector valid, one cycle after an acknowledge |
| vec | output | 8 | Returned vector |

## Verification
The bench targets several corner cases, each tied to a specific wrong behaviour:
- Two sources at the same level. A resolver with the wrong scan direction would return the higher index first.
- An acknowledge with no qualifying source. A missing fallback would return a stale or base-relative vector instead of 0xFF.
- A rising request in the same cycle as a write-one clear. A design that lets the clear win would lose the event.
- A software byte written with both clear and enable set. A set-wins design would leave the interrupt pending.

Further checks cover the following:
- The two-stage abort path is checked cycle by cycle; a missing or extra stage shifts bit 6 and the pending flag by one edge.
- A base near 0xFF checks the vector wraps modulo 256.
- Disabling the global enable while sources are pending checks that nothing leaks to `irq_lvl`.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [1:0] {
      SK_LEVEL  = 2'd0,
      SK_EDGE   = 2'd1,
      SK_SOFT   = 2'd2,
      SK_SWITCH = 2'd3
   } src_kind_e;

   localparam int CTL_PEND_BIT = 7;
   localparam int CTL_SW_BIT   = 6;
   localparam int CTL_EN_BIT   = 3;
   localparam int GEN_IEN_BIT  = 4;
   localparam int BYTE_W       = 8;

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("vic_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= RESET_VAL;
            else        s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= {STAGES{RESET_VAL}};
            else        s_q <= {s_q[STAGES-2:0], d};
         end
         assign q = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/vic_src_slot.sv
module vic_src_slot
   import vic_pkg::*;
#(
   parameter src_kind_e KIND  = SK_LEVEL,
   parameter int        LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic             w_clr,
   input  logic             w_en,
   input  logic [LVL_W-1:0] w_lvl,
   input  logic             req,
   input  logic             sw_fall,
   input  logic             ack_clr,
   output logic             en,
   output logic [LVL_W-1:0] lvl,
   output logic             pend
);

   logic             en_q;
   logic [LVL_W-1:0] lvl_q;
   logic             pend_q;
   logic             req_d;
   logic             pend_nxt;
   logic             set_ev;
   logic             clr_ev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         lvl_q <= '0;
      end else if (wr_sel) begin
         en_q  <= w_en;
         lvl_q <= w_lvl;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= req;
   end

   always_comb begin
      set_ev   = 1'b0;
      clr_ev   = 1'b0;
      pend_nxt = pend_q;
      case (KIND)
         SK_LEVEL: begin
            pend_nxt = req;
         end
         SK_EDGE: begin
            set_ev   = req & ~req_d;
            clr_ev   = (wr_sel & w_clr) | ack_clr;
            pend_nxt = set_ev | (pend_q & ~clr_ev);
         end
         SK_SOFT: begin
            set_ev   = wr_sel & w_en;
            clr_ev   = wr_sel & w_clr;
            pend_nxt = ~clr_ev & (set_ev | pend_q);
         end
         default: begin
            set_ev   = sw_fall;
            clr_ev   = (wr_sel & w_clr) | ack_clr;
            pend_nxt = set_ev | (pend_q & ~clr_ev);
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_nxt;
   end

   assign en   = en_q;
   assign lvl  = lvl_q;
   assign pend = pend_q;

endmodule

// File: rtl/vic_resolve.sv
module vic_resolve #(
   parameter int N_SRC = 12,
   parameter int LVL_W = 3,
   parameter int IDX_W = 4
) (
   input  logic [N_SRC-1:0]       active,
   input  logic [N_SRC*LVL_W-1:0] lvl_flat,
   input  logic [LVL_W-1:0]       q_lvl,
   output logic [LVL_W-1:0]       top_lvl,
   output logic                   hit,
   output logic [IDX_W-1:0]       hit_idx
);

   always_comb begin
      top_lvl = '0;
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (active[i] && (lvl_flat[i*LVL_W +: LVL_W] > top_lvl))
            top_lvl = lvl_flat[i*LVL_W +: LVL_W];
         if (!hit && active[i] && (q_lvl != '0) &&
             (lvl_flat[i*LVL_W +: LVL_W] == q_lvl)) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/vic_top.sv
module vic_top
   import vic_pkg::*;
#(
   parameter int          N_SRC       = 12,
   parameter int          LVL_W       = 3,
   parameter int          ADDR_W      = 4,
   parameter int          VEC_W       = 8,
   parameter int          ABORT_IDX   = 2,
   parameter int          SOFT_A_IDX  = 10,
   parameter int          SYNC_STAGES = 2,
   parameter logic [VEC_W-1:0]   SPUR_VEC = 8'hFF,
   parameter logic [2*N_SRC-1:0] SRC_KIND = 24'hA51034
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [N_SRC-1:0]  src_req,
   input  logic              abort_n,
   input  logic              iack,
   input  logic [LVL_W-1:0]  iack_lvl,
   output logic [LVL_W-1:0]  irq_lvl,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec
);

   localparam int IDX_W     = $clog2(N_SRC);
   localparam int GEN_ADDR  = N_SRC;
   localparam int BASE_ADDR = N_SRC + 1;

   generate
      if (N_SRC + 2 > (1 << ADDR_W)) begin : g_chk_addr
         $error("vic_top: ADDR_W too narrow for N_SRC");
      end
      if (LVL_W > CTL_EN_BIT) begin : g_chk_lvl
         $error("vic_top: LVL_W collides with the enable bit");
      end
      if (VEC_W != BYTE_W) begin : g_chk_vec
         $error("vic_top: VEC_W must equal the register width");
      end
      if (IDX_W > VEC_W) begin : g_chk_idx
         $error("vic_top: source index wider than vector");
      end
      if (ABORT_IDX >= N_SRC || SOFT_A_IDX >= N_SRC) begin : g_chk_idxr
         $error("vic_top: source index parameter out of range");
      end
      if (SRC_KIND[2*ABORT_IDX +: 2] != 2'(SK_SWITCH)) begin : g_chk_ab
         $error("vic_top: abort slot must be of switch kind");
      end
   endgenerate

   logic              ge_q;
   logic [VEC_W-1:0]  base_q;
   logic              vv_q;
   logic [VEC_W-1:0]  vec_q;

   logic              sw_q;
   logic              sw_d;
   logic              sw_fall;

   logic [N_SRC-1:0]       wr_sel;
   logic [N_SRC-1:0]       ack_clr;
   logic [N_SRC-1:0]       en_v;
   logic [N_SRC-1:0]       pend_v;
   logic [N_SRC-1:0]       active;
   logic [N_SRC*LVL_W-1:0] lvl_flat;

   logic [LVL_W-1:0] top_lvl;
   logic             hit;
   logic [IDX_W-1:0] hit_idx;

   vic_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (abort_n),
      .q    (sw_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) sw_d <= 1'b1;
      else        sw_d <= sw_q;
   end
   assign sw_fall = sw_d & ~sw_q;

   generate
      for (genvar gi = 0; gi < N_SRC; gi++) begin : g_slot
         localparam src_kind_e KND = src_kind_e'(SRC_KIND[2*gi +: 2]);
         assign wr_sel[gi]  = reg_wr && (reg_addr == ADDR_W'(gi));
         assign ack_clr[gi] = iack && hit && (hit_idx == IDX_W'(gi));

         vic_src_slot #(
            .KIND (KND),
            .LVL_W(LVL_W)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_sel[gi]),
            .w_clr  (reg_wdata[CTL_PEND_BIT]),
            .w_en   (reg_wdata[CTL_EN_BIT]),
            .w_lvl  (reg_wdata[LVL_W-1:0]),
            .req    (src_req[gi]),
            .sw_fall((gi == ABORT_IDX) ? sw_fall : 1'b0),
            .ack_clr(ack_clr[gi]),
            .en     (en_v[gi]),
            .lvl    (lvl_flat[gi*LVL_W +: LVL_W]),
            .pend   (pend_v[gi])
         );
      end
   endgenerate

   assign active = pend_v & en_v & {N_SRC{ge_q}};

   vic_resolve #(
      .N_SRC(N_SRC),
      .LVL_W(LVL_W),
      .IDX_W(IDX_W)
   ) u_res (
      .active  (active),
      .lvl_flat(lvl_flat),
      .q_lvl   (iack_lvl),
      .top_lvl (top_lvl),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ge_q   <= 1'b0;
         base_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(GEN_ADDR))  ge_q   <= reg_wdata[GEN_IEN_BIT];
         if (reg_addr == ADDR_W'(BASE_ADDR)) base_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vv_q  <= 1'b0;
         vec_q <= '0;
      end else begin
         vv_q <= iack;
         if (iack) vec_q <= hit ? (base_q + VEC_W'(hit_idx)) : SPUR_VEC;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (reg_addr == ADDR_W'(i)) begin
            reg_rdata[CTL_PEND_BIT]  = pend_v[i];
            reg_rdata[CTL_SW_BIT]    = (i == ABORT_IDX) ? ~sw_q : 1'b0;
            reg_rdata[CTL_EN_BIT]    = en_v[i];
            reg_rdata[LVL_W-1:0]     = lvl_flat[i*LVL_W +: LVL_W];
         end
      end
      if (reg_addr == ADDR_W'(GEN_ADDR))  reg_rdata[GEN_IEN_BIT] = ge_q;
      if (reg_addr == ADDR_W'(BASE_ADDR)) reg_rdata = base_q;
   end

   assign irq_lvl   = top_lvl;
   assign vec_valid = vv_q;
   assign vec       = vec_q;

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int N_SRC      = 12,
   parameter int LVL_W      = 3,
   parameter int ADDR_W     = 4,
   parameter int ABORT_IDX  = 2,
   parameter int SOFT_A_IDX = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ge,
   input logic [LVL_W-1:0]  irq_lvl,
   input logic              iack,
   input logic              vec_valid,
   input logic [N_SRC-1:0]  pend,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic              wclr,
   input logic              sw_fall
);

   // R3: nothing presented while the global enable is off
   a_r3_gate_off : assert property (@(posedge clk) disable iff (!rst_n)
      !ge |-> (irq_lvl == '0));

   // R3: a nonzero level needs some pending source
   a_r3_needs_pend : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lvl != '0) |-> (|pend));

   // R4: vector strobe follows the acknowledge by one cycle
   a_r4_vec_follows : assert property (@(posedge clk) disable iff (!rst_n)
      iack |=> vec_valid);

   a_r4_vec_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !iack |=> !vec_valid);

   // R10: write-one clear of a software source always wins
   a_r10_soft_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(SOFT_A_IDX) && wclr) |=> !pend[SOFT_A_IDX]);

   // R11: a synchronised falling edge latches the abort source
   a_r11_abort_latch : assert property (@(posedge clk) disable iff (!rst_n)
      sw_fall |=> pend[ABORT_IDX]);

endmodule

bind vic_top vic_chk #(
   .N_SRC     (N_SRC),
   .LVL_W     (LVL_W),
   .ADDR_W    (ADDR_W),
   .ABORT_IDX (ABORT_IDX),
   .SOFT_A_IDX(SOFT_A_IDX)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ge       (ge_q),
   .irq_lvl  (irq_lvl),
   .iack     (iack),
   .vec_valid(vec_valid),
   .pend     (pend_v),
   .wr       (reg_wr),
   .addr     (reg_addr),
   .wclr     (reg_wdata[7]),
   .sw_fall  (sw_fall)
);

// File: tb/vic_top_tb_top.sv
`timescale 1ns/1ps
module vic_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [11:0] req = '0;
   logic        abort_n = 1'b1;
   logic        iack = 1'b0;
   logic [2:0]  iack_lvl = '0;
   logic [2:0]  irq_lvl;
   logic        vec_valid;
   logic [7:0]  vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   vic_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .src_req(req),
      .abort_n(abort_n), .iack(iack), .iack_lvl(iack_lvl),
      .irq_lvl(irq_lvl), .vec_valid(vec_valid), .vec(vec)
   );

   // ---------------- reference model ----------------
   bit m_en[12];
   int m_lv[12];
   bit m_p[12];
   bit m_prev[12];
   bit np[12];
   bit m_ge;
   int m_base;
   bit m_a, m_b, m_c;
   bit m_vv;
   int m_vec;
   int hit_i;

   function automatic int kind_of(int i);
      if (i == 1 || i == 6 || i == 8 || i == 9) return 1;
      if (i == 10 || i == 11) return 2;
      if (i == 2) return 3;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 12; i++) begin
            m_en[i] = 0; m_lv[i] = 0; m_p[i] = 0; m_prev[i] = 0;
         end
         m_ge = 0; m_base = 0; m_a = 1; m_b = 1; m_c = 1; m_vv = 0; m_vec = 0;
      end else begin
         hit_i = -1;
         if (iack && iack_lvl != 0)
            for (int i = 0; i < 12; i++)
               if (hit_i < 0 && m_ge && m_en[i] && m_p[i] && m_lv[i] == int'(iack_lvl))
                  hit_i = i;
         for (int i = 0; i < 12; i++) begin
            bit ws, wc, ac;
            ws = wr && (int'(addr) == i);
            wc = ws && wdata[7];
            ac = (hit_i == i);
            case (kind_of(i))
               0: np[i] = req[i];
               1: np[i] = (req[i] && !m_prev[i]) || (m_p[i] && !(wc || ac));
               2: np[i] = !wc && ((ws && wdata[3]) || m_p[i]);
               default: np[i] = (m_c && !m_b) || (m_p[i] && !(wc || ac));
            endcase
         end
         m_vv = iack;
         if (iack) m_vec = (hit_i >= 0) ? ((m_base + hit_i) % 256) : 255;
         for (int i = 0; i < 12; i++) begin
            m_p[i] = np[i];
            m_prev[i] = req[i];
            if (wr && int'(addr) == i) begin
               m_en[i] = wdata[3];
               m_lv[i] = int'(wdata[2:0]);
            end
         end
         if (wr && addr == 4'd12) m_ge = wdata[4];
         if (wr && addr == 4'd13) m_base = int'(wdata);
         m_c = m_b; m_b = m_a; m_a = abort_n;
      end
   end

   function automatic int exp_irq();
      int best = 0;
      for (int i = 0; i < 12; i++)
         if (m_ge && m_en[i] && m_p[i] && m_lv[i] > best) best = m_lv[i];
      return best;
   endfunction

   function automatic int exp_rd(int a);
      if (a < 12)
         return (m_p[a] ? 128 : 0) + ((a == 2 && !m_b) ? 64 : 0) +
                (m_en[a] ? 8 : 0) + m_lv[a];
      if (a == 12) return m_ge ? 16 : 0;
      if (a == 13) return m_base;
      return 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R3 irq_lvl", int'(irq_lvl), exp_irq());
         chk("R4 vec_valid", int'(vec_valid), int'(m_vv));
         if (m_vv) chk("R4 vec", int'(vec), m_vec);
         chk("R2 rdata", int'(rdata), exp_rd(int'(addr)));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wreg(int a, int d);
      @(negedge clk); wr = 1; addr = 4'(a); wdata = 8'(d);
      @(negedge clk); wr = 0;
   endtask

   task automatic rd(int a, int exp, string tag);
      @(negedge clk); addr = 4'(a);
      #1 chk(tag, int'(rdata), exp);
   endtask

   task automatic irq_is(int exp, string tag);
      @(negedge clk);
      #1 chk(tag, int'(irq_lvl), exp);
   endtask

   task automatic ack(int l, int exp, string tag);
      @(negedge clk); iack = 1; iack_lvl = 3'(l);
      @(negedge clk); iack = 0; iack_lvl = 0;
      #1 chk({tag, " valid"}, int'(vec_valid), 1);
      chk(tag, int'(vec), exp);
   endtask

   task automatic pulse(int i);
      @(negedge clk); req[i] = 1;
      @(negedge clk); req[i] = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(8, 8'h00, "R1 ctrl8");
      rd(12, 8'h00, "R1 gen");
      rd(13, 8'h00, "R1 base");
      rd(2, 8'h00, "R1 abort byte");
      irq_is(0, "R1 irq");
      // R2 base and general control
      wreg(13, 8'h40);
      wreg(12, 8'hFF);
      rd(12, 8'h10, "R2 gen only bit4");
      // R7 edge via timer1 (idx 8) lvl 5
      wreg(8, 8'h0D);
      pulse(8);
      irq_is(5, "R3 single edge");
      rd(8, 8'h8D, "R7 latched");
      ack(5, 8'h48, "R4 timer1 vector");
      rd(8, 8'h0D, "R7 ack clears");
      // R5 tie between 1 and 6 at lvl 4
      wreg(1, 8'h0C);
      wreg(6, 8'h0C);
      @(negedge clk); req[1] = 1; req[6] = 1;
      @(negedge clk); req[1] = 0; req[6] = 0;
      irq_is(4, "R3 tie level");
      ack(4, 8'h41, "R5 lower first");
      ack(4, 8'h46, "R5 second");
      ack(4, 8'hFF, "R6 none left");
      // R8 level source 4 lvl 6
      wreg(4, 8'h0E);
      @(negedge clk); req[4] = 1;
      irq_is(6, "R8 level raise");
      wreg(4, 8'h8E);
      rd(4, 8'h8E, "R8 w1c ignored");
      ack(6, 8'h44, "R4 level vector");
      rd(4, 8'h8E, "R8 ack ignored");
      @(negedge clk); req[4] = 0;
      rd(4, 8'h0E, "R8 follows req");
      // R7 write-one clear on idx 9
      wreg(9, 8'h0A);
      pulse(9);
      rd(9, 8'h8A, "R7 idx9 set");
      wreg(9, 8'h8A);
      rd(9, 8'h0A, "R7 w1c");
      // R9 set and clear in the same cycle
      @(negedge clk); req[9] = 1; wr = 1; addr = 4'd9; wdata = 8'h8A;
      @(negedge clk); req[9] = 0; wr = 0;
      rd(9, 8'h8A, "R9 set wins");
      wreg(9, 8'h8A);
      // R10 software sources
      wreg(10, 8'h0B);
      rd(10, 8'h8B, "R10 soft set");
      irq_is(3, "R10 soft level");
      ack(3, 8'h4A, "R4 soft vector");
      rd(10, 8'h8B, "R10 ack no clear");
      wreg(10, 8'h88);
      rd(10, 8'h08, "R10 clear wins");
      wreg(11, 8'h01);
      pulse(11);
      rd(11, 8'h01, "R10 req ignored");
      wreg(11, 8'h09);
      rd(11, 8'h89, "R10 soft2 set");
      wreg(11, 8'h80);
      rd(11, 8'h00, "R10 soft2 clear");
      // R11 abort synchroniser
      wreg(2, 8'h0F);
      @(negedge clk); abort_n = 0;
      rd(2, 8'h0F, "R11 edge1");
      rd(2, 8'h4F, "R11 edge2 live");
      rd(2, 8'hCF, "R11 edge3 pend");
      irq_is(7, "R11 irq");
      @(negedge clk); abort_n = 1;
      ack(7, 8'h42, "R11 vector");
      repeat (3) @(negedge clk);
      rd(2, 8'h0F, "R11 cleared");
      // R3 global enable
      wreg(5, 8'h0B);
      @(negedge clk); req[5] = 1;
      irq_is(3, "R3 scsi level");
      wreg(12, 8'h00);
      irq_is(0, "R3 global off");
      ack(3, 8'hFF, "R6 global off vector");
      wreg(12, 8'h10);
      irq_is(3, "R3 global on");
      // R3 level zero never raises
      wreg(7, 8'h08);
      @(negedge clk); req[5] = 0; req[7] = 1;
      irq_is(0, "R3 level zero");
      @(negedge clk); req[7] = 0;
      // R12 latched while disabled
      wreg(1, 8'h04);
      pulse(1);
      irq_is(0, "R12 disabled quiet");
      rd(1, 8'h84, "R12 held");
      wreg(1, 8'h0C);
      irq_is(4, "R12 enabled");
      ack(4, 8'h41, "R12 vector");
      // R4 wrap of base plus index
      wreg(13, 8'hF8);
      wreg(11, 8'h0E);
      ack(6, 8'h03, "R4 wrap");
      wreg(11, 8'h80);
      // R2 unmapped addresses
      wreg(14, 8'hFF);
      rd(14, 8'h00, "R2 unmapped");
      rd(13, 8'hF8, "R2 base kept");
      rd(15, 8'h00, "R2 unmapped hi");
      irq_is(0, "R3 idle end");
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule